// File: doc/BRIEF.md
# SD Command Line Engine

This block drives the command line of an SD/MMC card. It sends one command token and, if asked, takes in the card's reply. Software first writes a 32-bit argument. It then writes a control word. That single write selects the command index, whether a reply is expected and whether the reply is long, and it launches the command at once. The engine shifts out a 48-bit token, one bit per card-clock strobe. The token carries a CRC7 checksum. If a reply is expected, the engine waits for the card's start bit and then shifts in a 48-bit or 136-bit reply.

When the command finishes, a status word gives the outcome: response received, timeout or CRC error. The reply is presented as four 32-bit words. Three sticky interrupt causes record the outcome: command sent, timeout and CRC error. Software clears each cause by writing 1 to its bit. The card clock is not a clock here: it arrives as a one-cycle enable strobe `card_stb` in the system clock domain.

The controller has four states:
- `ST_IDLE` goes to `ST_SEND` on a launching control write.
- `ST_SEND` goes to `ST_WAIT` after the 48th bit when a reply is expected, and otherwise back to `ST_IDLE`.
- `ST_WAIT` goes to `ST_RECV` when it samples a start bit, or to `ST_IDLE` on timeout.
- `ST_RECV` goes to `ST_IDLE` after the reply's end bit.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, `cmd_oe` is 0, `cmd_out` is 1, `status` is 0, `irq_cause` is 0 and `rsp_data` is 0. Whenever `cmd_oe` is low, `cmd_out` is 1.
- R2: Writes select a register through `reg_addr`: 0 is the argument, 1 is the control word and 2 is the interrupt clear. A control write made while idle with bit 8 set launches a command. In that word, bits 5:0 are the index, bit 9 requests a reply and bit 10 selects a 136-bit reply.
- R3: The token is sent MSB first, one bit per strobe, with `cmd_oe` high for exactly 48 strobes. Its layout is {0, 1, index[5:0], argument[31:0], CRC7, 1}. The CRC7 uses polynomial x^7+x^3+1 and covers the first 40 bits.
- R4: With bit 9 clear, the command ends after the token's last bit. `status` then reads 0x0800 (bit 11 is end) and cause bit 0 (command sent) is set.
- R5: A 48-bit reply {0, 0, index, payload[31:0], CRC7, 1} with a good CRC gives these results:
  - `status` reads 0x0A00 with the reply index in bits 7:0 (bit 9 is reply received).
  - Word 0 (`rsp_data[31:0]`) holds the payload, and words 1 to 3 are 0.
  - Cause bit 0 is set.
- R6: A 136-bit reply is handled as follows:
  - Its last 128 bits fill the four words, most significant first: word 0 holds bits 127:96.
  - The CRC7 check covers only bits 127:1.
  - The 6 bits after the transmission bit are reported in `status[7:0]` and are not checked.
- R7: A CRC mismatch sets `status` bit 12 and cause bit 2 in addition to bit 9 and cause bit 0. The reply words are still stored.
- R8: Timeout works as follows:
  - A start bit accepted within the first 64 strobes after the token ends gives a normal reply.
  - 64 strobes with the line high end the command with `status` 0x0C00 (bit 10 is timeout), cause bit 1 set and all reply words 0.
- R9: `status` bit 8 (busy) is high from launch until the command ends.
- R10: A write to address 2 clears each cause whose bit is 1: data bit 6 clears cause 0, bit 7 clears cause 1 and bit 8 clears cause 2. Written zeros leave causes unchanged.
- R11: These writes have no effect: a control write with bit 8 clear, and any argument or control write made while busy. A later command uses the argument written while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_stb | input | 1 | One-cycle card clock enable; one line bit per strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 argument, 1 control, 2 interrupt clear |
| reg_wdata | input | 32 | Write data |
| cmd_in | input | 1 | Command line as seen from the card |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line output enable |
| status | output | 16 | Reply index, busy, reply, timeout, end and CRC error flags |
| rsp_data | output | 128 | Four reply words; word k is bits 32k+31:32k |
| irq_cause | output | 3 | Sticky causes: sent, timeout, CRC error |

## Verification
The bench sweeps all 64 command indices with no reply. Each index carries a distinct argument, so every CRC7 and token bit position is covered, and a wrong bit order or shift length is caught. Short replies use several indices and payloads at start delays of 0, 5 and 63 strobes, which separates the last accepted delay from a timeout at 64. Long replies are checked for word order, with a scrambled reserved field that must not fault and a flipped content bit that must. Register writes made while busy or without the start bit are shown to leave the next token, the status and the causes unchanged.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV
    } cmd_state_e;

    localparam logic [1:0] ADDR_ARG  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_ICLR = 2'd2;

    localparam int CTL_START = 8;
    localparam int CTL_WAIT  = 9;
    localparam int CTL_LONG  = 10;
    localparam int INT_BASE  = 6;
    localparam int INT_COUNT = 3;

    localparam int TX_BITS    = 48;
    localparam int SHORT_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int LONG_CRC_FIRST = 8;

    localparam logic [6:0] CRC7_POLY = 7'h09;

    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? CRC7_POLY : 7'h00);
    endfunction

    function automatic logic [6:0] crc7_word(input logic [39:0] m);
        logic [6:0] c;
        c = 7'h00;
        for (int i = 39; i >= 0; i--) begin
            c = crc7_step(c, m[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/sd_cmd_crc7.sv
module sd_cmd_crc7
    import sd_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= 7'h00;
        end else if (clr) begin
            crc <= 7'h00;
        end else if (en) begin
            crc <= crc7_step(crc, din);
        end
    end
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] tok,
    input  logic         shift,
    output logic         bit_o
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else if (load) begin
            sh_q <= tok;
        end else if (shift) begin
            sh_q <= {sh_q[W-2:0], 1'b1};
        end
    end

    assign bit_o = sh_q[W-1];
endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx #(
    parameter int W = 136
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (clr) begin
            data <= '0;
        end else if (shift) begin
            data <= {data[W-2:0], din};
        end
    end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int TMO_STROBES = 64,
    parameter int RSP_WORDS   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         card_stb,
    input  logic         reg_we,
    input  logic [1:0]   reg_addr,
    input  logic [31:0]  reg_wdata,
    input  logic         cmd_in,
    output logic         cmd_out,
    output logic         cmd_oe,
    output logic [15:0]  status,
    output logic [127:0] rsp_data,
    output logic [2:0]   irq_cause
);
    localparam int CNT_W = $clog2(LONG_BITS);
    localparam int TMO_W = $clog2(TMO_STROBES + 1);

    cmd_state_e state_q, state_d;

    logic [31:0]      arg_q;
    logic             wait_q, long_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [TMO_W-1:0] tmo_cnt;
    logic             busy_q, rsp_q, tmo_q, end_q, crc_err_q;
    logic [INT_COUNT-1:0] int_q, int_set, int_clr;

    logic [TX_BITS-1:0]   tx_tok;
    logic                 tx_bit;
    logic [LONG_BITS-1:0] rx_data;
    logic [6:0]           crc_q;

    logic launch, tx_done, start_seen, tmo_hit, rx_done, crc_en;
    logic [CNT_W-1:0] rx_last;

    assign launch     = (state_q == ST_IDLE) && reg_we && (reg_addr == ADDR_CTRL)
                        && reg_wdata[CTL_START];
    assign tx_done    = (state_q == ST_SEND) && card_stb && (bit_cnt == CNT_W'(TX_BITS - 1));
    assign start_seen = (state_q == ST_WAIT) && card_stb && !cmd_in;
    assign tmo_hit    = (state_q == ST_WAIT) && card_stb && cmd_in
                        && (tmo_cnt == TMO_W'(TMO_STROBES - 1));
    assign rx_last    = long_q ? CNT_W'(LONG_BITS - 1) : CNT_W'(SHORT_BITS - 1);
    assign rx_done    = (state_q == ST_RECV) && card_stb && (bit_cnt == rx_last);
    assign crc_en     = (state_q == ST_RECV) && card_stb && !rx_done
                        && (!long_q || (bit_cnt >= CNT_W'(LONG_CRC_FIRST)));

    assign tx_tok = {2'b01, reg_wdata[5:0], arg_q,
                     crc7_word({2'b01, reg_wdata[5:0], arg_q}), 1'b1};

    sd_cmd_tx #(.W(TX_BITS)) tx_i (
        .clk(clk), .rst_n(rst_n), .load(launch), .tok(tx_tok),
        .shift((state_q == ST_SEND) && card_stb), .bit_o(tx_bit)
    );

    sd_cmd_rx #(.W(LONG_BITS)) rx_i (
        .clk(clk), .rst_n(rst_n), .clr(launch),
        .shift((state_q == ST_RECV) && card_stb), .din(cmd_in), .data(rx_data)
    );

    sd_cmd_crc7 crc_i (
        .clk(clk), .rst_n(rst_n), .clr(launch), .en(crc_en), .din(cmd_in), .crc(crc_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch)     state_d = ST_SEND;
            ST_SEND: if (tx_done)    state_d = wait_q ? ST_WAIT : ST_IDLE;
            ST_WAIT: if (start_seen) state_d = ST_RECV;
                     else if (tmo_hit) state_d = ST_IDLE;
            ST_RECV: if (rx_done)    state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    assign int_set = {rx_done && (crc_q != 7'h00), tmo_hit, (tx_done && !wait_q) || rx_done};
    assign int_clr = (reg_we && reg_addr == ADDR_ICLR) ? reg_wdata[INT_BASE +: INT_COUNT]
                                                        : '0;

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q <= '0; wait_q <= 1'b0; long_q <= 1'b0;
            bit_cnt <= '0; tmo_cnt <= '0;
            busy_q <= 1'b0; rsp_q <= 1'b0; tmo_q <= 1'b0; end_q <= 1'b0; crc_err_q <= 1'b0;
            int_q <= '0;
        end else begin
            if (reg_we && reg_addr == ADDR_ARG && state_q == ST_IDLE) arg_q <= reg_wdata;
            int_q <= (int_q & ~int_clr) | int_set;
            unique case (state_q)
                ST_IDLE: if (launch) begin
                    wait_q <= reg_wdata[CTL_WAIT];
                    long_q <= reg_wdata[CTL_LONG];
                    bit_cnt <= '0; tmo_cnt <= '0;
                    busy_q <= 1'b1; rsp_q <= 1'b0; tmo_q <= 1'b0;
                    end_q <= 1'b0; crc_err_q <= 1'b0;
                end
                ST_SEND: if (card_stb) begin
                    if (tx_done) begin
                        bit_cnt <= '0;
                        if (!wait_q) begin busy_q <= 1'b0; end_q <= 1'b1; end
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
                ST_WAIT: if (card_stb) begin
                    if (!cmd_in)      bit_cnt <= CNT_W'(1);
                    else if (tmo_hit) begin busy_q <= 1'b0; end_q <= 1'b1; tmo_q <= 1'b1; end
                    else              tmo_cnt <= tmo_cnt + TMO_W'(1);
                end
                ST_RECV: if (card_stb) begin
                    if (rx_done) begin
                        busy_q <= 1'b0; end_q <= 1'b1; rsp_q <= 1'b1;
                        crc_err_q <= (crc_q != 7'h00);
                    end else begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    logic [5:0] rx_idx;
    assign rx_idx = long_q ? rx_data[133:128] : rx_data[45:40];
    assign status = {3'b000, crc_err_q, end_q, tmo_q, rsp_q, busy_q,
                     rsp_q ? {2'b00, rx_idx} : 8'h00};

    for (genvar k = 0; k < RSP_WORDS; k++) begin : g_word
        if (k == 0) begin : g_first
            assign rsp_data[31:0] = long_q ? rx_data[127:96] : rx_data[39:8];
        end else begin : g_rest
            assign rsp_data[32*k +: 32] = long_q ? rx_data[127-32*k -: 32] : 32'h0;
        end
    end

    assign cmd_oe    = (state_q == ST_SEND);
    assign cmd_out   = cmd_oe ? tx_bit : 1'b1;
    assign irq_cause = int_q;

    logic unused_bits;
    assign unused_bits = ^{reg_wdata[31:11], rx_data[135:134]};
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic       ctl_start,
    input logic       cmd_oe,
    input logic       cmd_out,
    input logic [4:0] st
);
    // st[0] busy, st[1] reply, st[2] timeout, st[3] end, st[4] crc error
    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out);
    assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st[0] && reg_we && reg_addr == 2'd1 && ctl_start) |=> st[0]);
    assert_drive_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> st[0]);
    assert_crc_needs_reply_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st[4] |-> st[1]);
    assert_timeout_no_reply_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st[2] |-> !st[1]);
    assert_end_on_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st[0]) |-> st[3]);
    assert_zero_ctrl_noop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!st[0] && reg_we && reg_addr == 2'd1 && !ctl_start) |=> (!st[0] && !cmd_oe && $stable(st)));
endmodule

bind sd_cmd_engine sd_cmd_engine_chk chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .ctl_start(reg_wdata[8]), .cmd_oe(cmd_oe), .cmd_out(cmd_out), .st(status[12:8])
);

// File: tb/sd_cmd_engine_tb.sv
`timescale 1ns/1ps
module sd_cmd_engine_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, card_stb = 1'b0, reg_we = 1'b0, cmd_in = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic cmd_out, cmd_oe;
    logic [15:0] status;
    logic [127:0] rsp_data;
    logic [2:0] irq_cause;

    sd_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .card_stb(card_stb), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .status(status),
        .rsp_data(rsp_data), .irq_cause(irq_cause)
    );

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    logic last_out, last_oe;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // remainder of m(x)*x^7 divided by x^7+x^3+1, long division form
    function automatic logic [6:0] ref_crc(input logic [127:0] m, input int n);
        logic [6:0] r;
        logic top, b;
        r = 7'h00;
        for (int k = n - 1; k >= -7; k--) begin
            b = (k >= 0) ? m[k] : 1'b0;
            top = r[6];
            r = {r[5:0], b};
            if (top) r = r ^ 7'h09;
        end
        return r;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic tick(input logic din);
        @(negedge clk);
        last_out = cmd_out; last_oe = cmd_oe;
        cmd_in = din; card_stb = 1'b1;
        @(negedge clk); card_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [5:0] idx, input logic [31:0] arg, input bit w, input bit l,
                        input bit wr_arg, input string tag);
        logic [47:0] exp_tok, got;
        bit oe_bad;
        exp_tok = {2'b01, idx, arg, ref_crc({88'h0, 2'b01, idx, arg}, 40), 1'b1};
        oe_bad = 1'b0;
        if (wr_arg) wr(2'd0, arg);
        wr(2'd1, 32'h140 | 32'(idx) | (32'(w) << 9) | (32'(l) << 10));
        chk(status[8] == 1'b1, {"R9 busy after launch ", tag}, 128'(status), 128'h100);
        for (int i = 0; i < 48; i++) begin
            tick(1'b1);
            got[47 - i] = last_out;
            if (!last_oe) oe_bad = 1'b1;
        end
        chk(got == exp_tok, {"R3 token ", tag}, 128'(got), 128'(exp_tok));
        chk(!oe_bad && !cmd_oe, {"R3 drive window ", tag}, 128'({oe_bad, cmd_oe}), 128'h0);
    endtask

    task automatic reply(input int delay, input logic [135:0] bits, input int n);
        for (int i = 0; i < delay; i++) tick(1'b1);
        for (int i = 0; i < n; i++) tick(bits[n - 1 - i]);
        @(negedge clk); cmd_in = 1'b1;
    endtask

    task automatic short_case(input logic [5:0] idx, input logic [31:0] pay, input int delay,
                              input bit corrupt, input string tag);
        logic [47:0] t;
        logic [6:0] c;
        c = ref_crc({88'h0, 2'b00, idx, pay}, 40);
        if (corrupt) c = c ^ 7'h10;
        t = {2'b00, idx, pay, c, 1'b1};
        wr(2'd2, 32'h1C0);
        send(idx, pay ^ 32'h5A5A0000, 1'b1, 1'b0, 1'b1, tag);
        chk(status[8] == 1'b1, {"R9 busy while waiting ", tag}, 128'(status), 128'h100);
        reply(delay, 136'(t), 48);
        if (!corrupt) begin
            chk(status == (16'h0A00 | 16'(idx)), {"R5 status ", tag}, 128'(status), 128'(16'h0A00 | 16'(idx)));
            chk(irq_cause == 3'b001, {"R5 cause ", tag}, 128'(irq_cause), 128'h1);
        end else begin
            chk(status == (16'h1A00 | 16'(idx)), {"R7 status ", tag}, 128'(status), 128'(16'h1A00 | 16'(idx)));
            chk(irq_cause == 3'b101, {"R7 cause ", tag}, 128'(irq_cause), 128'h5);
        end
        chk(rsp_data == {96'h0, pay}, {"R5 words ", tag}, rsp_data, {96'h0, pay});
    endtask

    task automatic long_case(input logic [5:0] rsv, input logic [119:0] body, input bit corrupt,
                             input string tag);
        logic [127:0] content;
        logic [135:0] t;
        content = {body, ref_crc({8'h0, body}, 120), 1'b1};
        t = {2'b00, rsv, content};
        if (corrupt) t[70] = ~t[70];
        wr(2'd2, 32'h1C0);
        send(6'd2, 32'h0, 1'b1, 1'b1, 1'b1, tag);
        reply(3, t, 136);
        chk(rsp_data == {t[31:0], t[63:32], t[95:64], t[127:96]}, {"R6 word order ", tag},
            rsp_data, {t[31:0], t[63:32], t[95:64], t[127:96]});
        if (!corrupt) begin
            chk(status == (16'h0A00 | 16'(rsv)), {"R6 status ", tag}, 128'(status), 128'(16'h0A00 | 16'(rsv)));
            chk(irq_cause == 3'b001, {"R6 cause ", tag}, 128'(irq_cause), 128'h1);
        end else begin
            chk(status == (16'h1A00 | 16'(rsv)), {"R7 long status ", tag}, 128'(status), 128'(16'h1A00 | 16'(rsv)));
            chk(irq_cause == 3'b101, {"R7 long cause ", tag}, 128'(irq_cause), 128'h5);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_oe == 1'b0 && cmd_out == 1'b1, "R1 line idle", 128'({cmd_oe, cmd_out}), 128'h1);
        chk(status == 16'h0 && irq_cause == 3'h0, "R1 status clear", 128'({status, irq_cause}), 128'h0);
        chk(rsp_data == 128'h0, "R1 words clear", rsp_data, 128'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4, R2: every index, no reply
        for (int i = 0; i < 64; i++) begin
            logic [31:0] a;
            a = (32'(i) * 32'h01010101) ^ 32'hA5A50F0F;
            send(6'(i), a, 1'b0, 1'b0, 1'b1, $sformatf("R2 idx %0d", i));
            chk(status == 16'h0800, "R4 end status", 128'(status), 128'h800);
            chk(irq_cause == 3'b001, "R4 sent cause", 128'(irq_cause), 128'h1);
            wr(2'd2, 32'h40);
            chk(irq_cause == 3'b000, "R10 clear sent", 128'(irq_cause), 128'h0);
        end

        // R11: zero control while idle
        send(6'd7, 32'h1234, 1'b0, 1'b0, 1'b1, "R11 prep");
        wr(2'd1, 32'h0000_063F);
        for (int i = 0; i < 3; i++) tick(1'b1);
        chk(!cmd_oe && status == 16'h0800 && irq_cause == 3'b001, "R11 zero control ignored",
            128'({cmd_oe, status, irq_cause}), 128'({1'b0, 16'h0800, 3'b001}));

        short_case(6'd0,  32'h0000_0000, 0,  1'b0, "R5 zero delay");
        short_case(6'd17, 32'hDEAD_BEEF, 5,  1'b0, "R5 delay 5");
        short_case(6'd63, 32'hFFFF_FFFF, 63, 1'b0, "R8 delay 63 accepted");
        short_case(6'd42, 32'h8001_7FFE, 2,  1'b1, "R7 short corrupt");

        // R10: zero write keeps, single-bit writes clear only their cause
        wr(2'd2, 32'h0);
        chk(irq_cause == 3'b101, "R10 zero write keeps", 128'(irq_cause), 128'h5);
        wr(2'd2, 32'h100);
        chk(irq_cause == 3'b001, "R10 clear crc cause", 128'(irq_cause), 128'h1);
        wr(2'd2, 32'h40);
        chk(irq_cause == 3'b000, "R10 clear sent cause", 128'(irq_cause), 128'h0);

        long_case(6'h3F, {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 24'hC0FFEE}, 1'b0, "R6 long");
        long_case(6'h15, {32'h0F0F0F0F, 32'hFFFF0000, 32'h13579BDF, 24'h2468AC}, 1'b0, "R6 rsv unchecked");
        long_case(6'h3F, {32'hCAFEF00D, 32'h00000001, 32'h80000000, 24'h5A5A5A}, 1'b1, "R7 long corrupt");

        // R8 timeout with R11 busy writes
        wr(2'd2, 32'h1C0);
        send(6'd5, 32'hA0A0_0505, 1'b1, 1'b0, 1'b1, "R8 timeout");
        for (int i = 0; i < 10; i++) tick(1'b1);
        wr(2'd0, 32'hBBBB_BBBB);
        wr(2'd1, 32'h149);
        chk(status[8] && !cmd_oe, "R11 busy writes ignored", 128'({status[8], cmd_oe}), 128'h2);
        for (int i = 0; i < 53; i++) tick(1'b1);
        chk(status == 16'h0100, "R8 still waiting after 63", 128'(status), 128'h100);
        tick(1'b1);
        chk(status == 16'h0C00, "R8 timeout status", 128'(status), 128'hC00);
        chk(irq_cause == 3'b010, "R8 timeout cause", 128'(irq_cause), 128'h2);
        chk(rsp_data == 128'h0, "R8 words zero", rsp_data, 128'h0);
        send(6'd12, 32'hA0A0_0505, 1'b0, 1'b0, 1'b0, "R11 argument kept");
        chk(status == 16'h0800, "R4 end after reuse", 128'(status), 128'h800);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule